// File: doc/BRIEF.md
# Sample Interleaving Packet Distributor

This block takes the demodulated sample words of one wavelength ramp and spreads them over M packets. Consecutive samples go to different packets in turn, so packet p holds samples p, p+M, p+2M and so on. If the network later drops one packet, the receiver loses every M-th sample across the whole ramp. It does not lose one contiguous stretch of the line shape, which matters most to a curve fit.

Samples arrive on a valid/ready stream. Each word can carry a ramp-start marker and a ramp-end marker. The block stores the ramp, and once the ramp ends it plays out packet 0, packet 1, up to packet M-1 on a valid/ready output stream. Each packet opens with a header word that carries the ramp number, the packet index and M. The downstream packet builder adds network framing and checksums. While a ramp is played out, the input is held off.

Top module: `ilv_packet_distributor`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `cfg_ratio_sel` values 0, 1, 2 and 3 select M = 1, 2, 4 and 8. Both `cfg_ratio_sel` and `cfg_narrow` are captured on the first accepted word of a ramp, and later changes within that ramp have no effect on that ramp's output.
- R3: Sample k of a ramp (k counted from 0) appears in packet k mod M at position floor(k/M) after the header. Packets appear in index order 0 to M-1.
- R4: Every packet starts with one header word flagged by `out_hdr`=1. In the header, bits [31:16] hold the ramp number, bits [15:8] hold the packet index, bits [7:4] hold M, and bits [3:0] are 0. Sample words carry `out_hdr`=0.
- R5: With M=1, a ramp comes out as a single packet whose samples are in arrival order.
- R6: A ramp of N samples gives packet p exactly ceil((N-p)/M) samples. A packet with no samples is still emitted as a header alone. `out_last` is 1 only on the final word of each packet.
- R7: From the cycle after a ramp's final word is accepted until the last output word of that ramp is accepted, `in_ready` is 0. Otherwise `in_ready` is 1.
- R8: In narrow mode (`cfg_narrow`=1), each sample word is output with bits [31:16] cleared and bits [15:0] kept. Header words are unaffected.
- R9: A ramp ends on an accepted word with `in_last`=1, or on its 1024th accepted word, whichever comes first.
- R10: An accepted word with `in_first`=1 becomes sample 0 of a new ramp. Words of an earlier ramp that never ended are discarded and never output.
- R11: The ramp number is 0 for the first ramp after reset and rises by 1 for each ramp played out.
- R12: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data`, `out_hdr` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ratio_sel | input | 2 | Interleave ratio select (M = 1 << value) |
| cfg_narrow | input | 1 | 16-bit sample mode |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Sample word |
| in_first | input | 1 | Word starts a new ramp |
| in_last | input | 1 | Word ends the ramp |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Header or sample word |
| out_hdr | output | 1 | Word is a packet header |
| out_last | output | 1 | Word is the final word of its packet |

## Verification
The bench drives ramp lengths that are not multiples of M, a five-sample ramp at M=8, and a single-word ramp. A wrong length formula would show up in these as a missing or extra word, or as `out_last` on the wrong word; dropping empty packets would show up as a missing header.

It also covers the following cases:
- A ramp is abandoned part-way and a new start marker follows; a design that ignored the marker would emit stale words.
- The ratio and width settings are changed mid-ramp; a design that failed to capture them on the first word would switch its layout partway through.
- An unterminated 1024-word ramp is sent, checking the forced end; without it the write index would wrap.
- `out_ready` is randomly stalled; a design that advanced on a stall would skip words or repeat header indices.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    localparam int HDR_RAMP_W  = 16;
    localparam int HDR_PKT_W   = 8;
    localparam int HDR_RATIO_W = 4;
    localparam int NARROW_W    = 16;
    localparam int MIN_DATA_W  = HDR_RAMP_W + HDR_PKT_W + HDR_RATIO_W + 4;

    function automatic logic [HDR_RATIO_W-1:0] ratio_of(input logic [1:0] sel);
        return HDR_RATIO_W'(1) << sel;
    endfunction
endpackage

// File: rtl/ilv_sample_store.sv
module ilv_sample_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/ilv_drain_seq.sv
module ilv_drain_seq
    import ilv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 11,
    localparam int ADDR_W = CNT_W - 1,
    localparam int WIDE_W = CNT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [1:0]        sel_i,
    input  logic              narrow_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_hdr,
    output logic              out_last
);
    typedef struct packed {
        logic                  active;
        logic [2:0]            pkt;
        logic [CNT_W-1:0]      slot;
        logic                  hdr;
        logic [CNT_W-1:0]      n;
        logic [1:0]            sel;
        logic                  narrow;
        logic [HDR_RAMP_W-1:0] ramp;
    } drain_t;

    drain_t q, d;
    logic [HDR_RATIO_W-1:0] ratio;
    logic [WIDE_W-1:0]      cur_addr, nxt_addr;
    logic                   pkt_last;
    logic [DATA_W-1:0]      hdr_word, smp_word;

    always_comb begin
        d        = q;
        ratio    = ratio_of(q.sel);
        cur_addr = (WIDE_W'(q.slot) << q.sel) | WIDE_W'(q.pkt);
        nxt_addr = (WIDE_W'(q.slot + 1'b1) << q.sel) | WIDE_W'(q.pkt);
        pkt_last = q.hdr ? (CNT_W'(q.pkt) >= q.n) : (nxt_addr >= WIDE_W'(q.n));

        hdr_word = '0;
        hdr_word[31:16] = q.ramp;
        hdr_word[15:8]  = HDR_PKT_W'(q.pkt);
        hdr_word[7:4]   = ratio;
        smp_word = rd_data_i;
        if (q.narrow) begin
            smp_word = DATA_W'(rd_data_i[NARROW_W-1:0]);
        end

        if (q.active && out_ready) begin
            if (pkt_last) begin
                if (HDR_RATIO_W'(q.pkt) + 1'b1 == ratio) begin
                    d.active = 1'b0;
                    d.ramp   = q.ramp + 1'b1;
                end else begin
                    d.pkt  = q.pkt + 1'b1;
                    d.slot = '0;
                    d.hdr  = 1'b1;
                end
            end else if (q.hdr) begin
                d.hdr = 1'b0;
            end else begin
                d.slot = q.slot + 1'b1;
            end
        end

        if (start_i && !q.active) begin
            d.active = 1'b1;
            d.pkt    = '0;
            d.slot   = '0;
            d.hdr    = 1'b1;
            d.n      = count_i;
            d.sel    = sel_i;
            d.narrow = narrow_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = q.active;
    assign rd_addr_o = cur_addr[ADDR_W-1:0];
    assign out_valid = q.active;
    assign out_hdr   = q.hdr;
    assign out_last  = q.active && pkt_last;
    assign out_data  = q.hdr ? hdr_word : smp_word;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_hdr) && $stable(out_last))); // R12
    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> (q.ramp == $past(q.ramp) + 1'b1)); // R11
    AST_HDR_PKT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hdr) |-> (HDR_RATIO_W'(out_data[15:8]) < out_data[7:4])); // R3
endmodule

// File: rtl/ilv_packet_distributor.sv
module ilv_packet_distributor
    import ilv_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int MAX_SAMPLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_ratio_sel,
    input  logic              cfg_narrow,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_hdr,
    output logic              out_last
);
    localparam int ADDR_W = $clog2(MAX_SAMPLES);
    localparam int CNT_W  = ADDR_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] wr_cnt;
        logic [1:0]       sel;
        logic             narrow;
    } fill_t;

    fill_t fq, fd;
    logic              rd_busy, accept, end_ramp, start_narrow;
    logic [1:0]        start_sel;
    logic [CNT_W-1:0]  idx, start_cnt;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    always_comb begin
        fd           = fq;
        accept       = in_valid && !rd_busy;
        idx          = in_first ? '0 : fq.wr_cnt;
        start_sel    = (idx == '0) ? cfg_ratio_sel : fq.sel;
        start_narrow = (idx == '0) ? cfg_narrow : fq.narrow;
        end_ramp     = accept && (in_last || idx == CNT_W'(MAX_SAMPLES - 1));
        start_cnt    = idx + 1'b1;
        if (accept) begin
            fd.sel    = start_sel;
            fd.narrow = start_narrow;
            fd.wr_cnt = end_ramp ? '0 : start_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fq <= '0;
        end else begin
            fq <= fd;
        end
    end

    assign in_ready = !rd_busy;

    ilv_sample_store #(
        .DATA_W (DATA_W),
        .DEPTH  (MAX_SAMPLES)
    ) store_i (
        .clk     (clk),
        .wr_en   (accept),
        .wr_addr (idx[ADDR_W-1:0]),
        .wr_data (in_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    ilv_drain_seq #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) drain_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (end_ramp),
        .count_i   (start_cnt),
        .sel_i     (start_sel),
        .narrow_i  (start_narrow),
        .busy_o    (rd_busy),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_hdr   (out_hdr),
        .out_last  (out_last)
    );

    AST_NO_INTAKE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R7
    AST_WR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (fq.wr_cnt < CNT_W'(MAX_SAMPLES))); // R9
    AST_RESET_IDLE: assert property (@(posedge clk)
        !$past(rst_n) |-> (!out_valid && in_ready)); // R1
endmodule

// File: tb/ilv_packet_distributor_tb_top.sv
module ilv_packet_distributor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXS       = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_ratio_sel = '0;
    logic        cfg_narrow = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_first = 1'b0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_hdr;
    logic        out_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_packet_distributor dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ratio_sel(cfg_ratio_sel), .cfg_narrow(cfg_narrow),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_first(in_first), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_hdr(out_hdr), .out_last(out_last)
    );

    typedef struct {
        logic [31:0] d;
        logic        h;
        logic        l;
    } beat_t;

    int          n_cmp = 0;
    int          n_bad = 0;
    beat_t       expq[$];
    logic [31:0] fillq[$];
    int          m_sel = 0;
    bit          m_nar = 0;
    int          m_ramp = 0;
    string       scen = "R1";
    bit          mon_on = 0;
    int          ready_mode = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s]: actual %h expected %h at %0t", req, scen, act, exp, $time);
        end
    endtask

    task automatic build_ramp();
        int m = 1 << m_sel;
        int n = fillq.size();
        for (int p = 0; p < m; p++) begin
            beat_t b;
            b.d = {m_ramp[15:0], 8'(p), 4'(m), 4'h0};
            b.h = 1'b1;
            b.l = (p >= n);
            expq.push_back(b);
            for (int k = p; k < n; k += m) begin
                b.d = m_nar ? {16'h0, fillq[k][15:0]} : fillq[k];
                b.h = 1'b0;
                b.l = (k + m >= n);
                expq.push_back(b);
            end
        end
        m_ramp++;
        fillq.delete();
    endtask

    always begin
        @(negedge clk);
        #1;
        if (mon_on) begin
            chk("R7", 32'(in_ready), 32'(expq.size() == 0));
            chk("R12", 32'(out_valid), 32'(expq.size() != 0));
            if (out_valid && expq.size() != 0) begin
                chk("R4", 32'(out_hdr), 32'(expq[0].h));
                chk(expq[0].h ? "R4" : "R3", out_data, expq[0].d);
                chk("R6", 32'(out_last), 32'(expq[0].l));
                if (out_ready) void'(expq.pop_front());
            end
            if (in_valid && in_ready) begin
                if (in_first) fillq.delete();
                if (fillq.size() == 0) begin
                    m_sel = int'(cfg_ratio_sel);
                    m_nar = cfg_narrow;
                end
                fillq.push_back(in_data);
                if (in_last || fillq.size() == MAXS) build_ramp();
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            out_ready = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
        end
    end

    task automatic send_ramp(int n, int sel, bit nar, bit mk_first, bit mk_last, int alt_sel, bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            @(negedge clk);
            in_valid      = 1'b1;
            in_data       = $urandom;
            in_first      = mk_first && (i == 0);
            in_last       = mk_last && (i == n - 1);
            cfg_ratio_sel = 2'((i == 0) ? sel : alt_sel);
            cfg_narrow    = (i == 0) ? nar : !nar;
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", 32'(out_valid), 32'd0);
        chk("R1", 32'(in_ready), 32'd1);
        mon_on = 1;

        scen = "R5";  send_ramp(10, 0, 0, 1, 1, 0, 0);   wait_drain();
        scen = "R6";  send_ramp(7, 1, 0, 1, 1, 1, 1);    wait_drain();
        scen = "R12"; ready_mode = 1;
                      send_ramp(13, 2, 0, 1, 1, 2, 1);   wait_drain();
        scen = "R6";  send_ramp(5, 3, 0, 1, 1, 3, 0);    wait_drain();
        scen = "R8";  send_ramp(64, 3, 1, 1, 1, 3, 1);   wait_drain();
        scen = "R10"; send_ramp(3, 1, 0, 0, 0, 1, 0);
                      send_ramp(9, 2, 0, 1, 1, 2, 0);    wait_drain();
        scen = "R2";  send_ramp(12, 1, 0, 1, 1, 3, 1);   wait_drain();
        scen = "R9";  ready_mode = 0;
                      send_ramp(MAXS, 2, 0, 1, 0, 2, 0); wait_drain();
        scen = "R11"; send_ramp(1, 1, 0, 1, 1, 1, 0);    wait_drain();
        scen = "R3";  ready_mode = 1;
                      send_ramp(30, 3, 0, 1, 1, 0, 1);   wait_drain();

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog: actual hung expected drained at %0t", $time);
        summary();
        $finish;
    end
endmodule